// File: doc/BRIEF.md
# Clock-Calendar Register Bank with Auto-Increment Pointer

This block holds the 32 byte-wide registers of a real-time clock and serves them to a byte-level serial target front end. The front end reports a start-of-write event, a start-of-read event, a stop event, each received data byte, and each request for a byte to send. The block keeps the register pointer and advances it after every data byte in either direction. Writes use the first byte after a write start as the address. A read start captures the live time into readable BCD registers.

The live time comes in as binary fields from a separate timekeeping counter. Writes to the time registers are not stored here. Each such write is decoded and handed back to the counter as a one-cycle load strobe with a field select. A weekday write is held until the stop event, so a date written later in the same burst is in place before the weekday is applied. The extension, flag and control registers follow per-bit write rules. The control register also offers a soft reset.

Top module: `rtc_regfile`

## Requirements
- R1: In a write transaction, the first data byte after the write start sets the pointer to its low 5 bits and is not stored in any register.
- R2: After every data byte written or read (address bytes excluded), the pointer advances by one, and 0x1F advances to 0x00.
- R3: A read start captures the live time as BCD into 0x00..0x06, with the same bytes readable at 0x10..0x16. The order is seconds, minutes, hours, weekday, day, month, two-digit year. The weekday byte is one-hot, with bit 0 for Sunday and bit 6 for Saturday.
- R4: When the pointer advances from 0x1F to 0x00, the live time is captured again in the same way as R3.
- R5: Addresses 0x1B..0x1F reach the same storage as 0x0B..0x0F, so a write through either address reads back through both.
- R6: Flag register (0x0E) bits 0, 1, 2, 6 and 7 can be cleared by a write but never set by one. Bits 3, 4 and 5 take the written value.
- R7: In the control register (0x0F), a write of 0 to 1 on bits 1 and 2 is masked off. A write with bit 0 set is a soft reset: extension becomes 0x02, control becomes 0x40, the flag register keeps only bits 0 and 1, and the pointer becomes 0x00.
- R8: After the synchronous reset, extension reads 0x02, control reads 0x40, flag reads 0x00, the pointer is 0x00, and rdata_valid_o and load_o are low.
- R9: A data write to a time field other than weekday pulses load_o for one cycle, starting the cycle after the byte. load_sel_o gives the field (0 sec, 1 min, 2 hour, 4 day, 5 month, 6 year). load_val_o gives the binary value of the BCD byte after masking: 0x7F for seconds and minutes, 0x3F for hour and day, 0x1F for month, none for year.
- R10: A weekday write (0x03 or 0x13) is held. On the next stop event, load_o pulses with load_sel_o = 3 and load_val_o = the index of the lowest set bit. If that index is 7 or there is no set bit, nothing is loaded.
- R11: Read data appears on rdata_o, with rdata_valid_o high, in the cycle after rdata_req_i.
- R12: Addresses 0x07..0x0C and 0x17..0x1A are plain read/write byte storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start_i | input | 1 | Start of a write transaction |
| rd_start_i | input | 1 | Start of a read transaction (captures time) |
| stop_i | input | 1 | End of transaction |
| wdata_valid_i | input | 1 | Strobe: a received byte is on wdata_i |
| wdata_i | input | 8 | Received byte |
| rdata_req_i | input | 1 | Request for the next byte to send |
| rdata_o | output | 8 | Byte to send |
| rdata_valid_o | output | 1 | rdata_o holds the requested byte |
| live_sec_i | input | 6 | Live seconds, binary |
| live_min_i | input | 6 | Live minutes, binary |
| live_hour_i | input | 5 | Live hours, binary |
| live_wday_i | input | 3 | Live weekday index, 0 = Sunday |
| live_mday_i | input | 5 | Live day of month, binary |
| live_mon_i | input | 4 | Live month 1..12, binary |
| live_year_i | input | 7 | Live year 0..99, binary |
| load_o | output | 1 | One-cycle preset strobe to the time counter |
| load_sel_o | output | 3 | Field being preset |
| load_val_o | output | 8 | Binary preset value |

## Verification
The assertions check on every cycle that the pointer steps and wraps correctly, that read data follows a request by exactly one cycle, and that no protected flag or control bit ever rises. They also check that a soft reset lands the documented values, and that load strobes arise only from a data byte or a stop. The bench scenarios show the rest: BCD capture values at the read start and at the wrap, aliasing between the two banks, masking and decoding of time writes, and the weekday preset held until stop. These depend on multi-byte transactions with known data.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_TIME = 7;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_DAY  = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6
  } field_e;

  localparam logic [BYTE_W-1:0] EXT_INIT      = 8'h02;
  localparam logic [BYTE_W-1:0] CTRL_INIT     = 8'h40;
  localparam logic [BYTE_W-1:0] FLAG_SURVIVE  = 8'h03;
  localparam logic [BYTE_W-1:0] FLAG_CLR_ONLY = 8'hC7;
  localparam logic [BYTE_W-1:0] CTRL_NO_SET   = 8'h06;
  localparam logic [BYTE_W-1:0] CTRL_SRST     = 8'h01;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] from_bcd(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] field_mask(input logic [2:0] f);
    case (f)
      3'd0, 3'd1: return 8'h7F;
      3'd2, 3'd4: return 8'h3F;
      3'd5:       return 8'h1F;
      default:    return 8'hFF;
    endcase
  endfunction

  function automatic logic [3:0] low_index(input logic [7:0] b);
    logic [3:0] r;
    r = 4'd8;
    for (int i = 7; i >= 0; i--) begin
      if (b[i]) r = 4'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_ptr_ctrl.sv
module rtc_ptr_ctrl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_start_i,
  input  logic          rd_start_i,
  input  logic          byte_in_i,
  input  logic [AW-1:0] byte_addr_i,
  input  logic          rd_req_i,
  input  logic          soft_rst_i,
  output logic [AW-1:0] ptr_o,
  output logic          addr_phase_o,
  output logic          data_wr_o,
  output logic          wrap_o
);

  logic [AW-1:0] ptr_q;
  logic          phase_q;
  logic          advance;

  assign data_wr_o    = byte_in_i && !phase_q;
  assign advance      = data_wr_o || rd_req_i;
  assign wrap_o       = advance && (ptr_q == '1) && !soft_rst_i;
  assign ptr_o        = ptr_q;
  assign addr_phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      phase_q <= 1'b0;
    end else if (soft_rst_i) begin
      ptr_q   <= '0;
      phase_q <= 1'b0;
    end else if (wr_start_i) begin
      phase_q <= 1'b1;
    end else if (rd_start_i) begin
      phase_q <= 1'b0;
    end else if (byte_in_i && phase_q) begin
      ptr_q   <= byte_addr_i;
      phase_q <= 1'b0;
    end else if (advance) begin
      ptr_q   <= ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_time_snap.sv
module rtc_time_snap
  import rtc_regfile_pkg::*;
#(
  parameter int NF = N_TIME
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       capture_i,
  input  logic [5:0] live_sec_i,
  input  logic [5:0] live_min_i,
  input  logic [4:0] live_hour_i,
  input  logic [2:0] live_wday_i,
  input  logic [4:0] live_mday_i,
  input  logic [3:0] live_mon_i,
  input  logic [6:0] live_year_i,
  output logic [7:0] snap_o [8]
);

  logic [7:0] live_bcd [NF];

  always_comb begin
    live_bcd[FLD_SEC]  = to_bcd(7'(live_sec_i));
    live_bcd[FLD_MIN]  = to_bcd(7'(live_min_i));
    live_bcd[FLD_HOUR] = to_bcd(7'(live_hour_i));
    live_bcd[FLD_WDAY] = 8'd1 << live_wday_i;
    live_bcd[FLD_DAY]  = to_bcd(7'(live_mday_i));
    live_bcd[FLD_MON]  = to_bcd(7'(live_mon_i));
    live_bcd[FLD_YEAR] = to_bcd(live_year_i);
  end

  for (genvar g = 0; g < NF; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)            snap_o[g] <= '0;
      else if (capture_i) snap_o[g] <= live_bcd[g];
    end
  end

  for (genvar g = NF; g < 8; g++) begin : g_pad
    assign snap_o[g] = '0;
  end

endmodule

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
  import rtc_regfile_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] ext_o,
  output logic [DW-1:0] flag_o,
  output logic [DW-1:0] ctrl_o,
  output logic          soft_rst_o
);

  logic wr_ext, wr_flag, wr_ctrl;

  assign wr_ext     = wr_i && (addr_i == 4'hD);
  assign wr_flag    = wr_i && (addr_i == 4'hE);
  assign wr_ctrl    = wr_i && (addr_i == 4'hF);
  assign soft_rst_o = wr_ctrl && data_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_o  <= EXT_INIT;
      ctrl_o <= CTRL_INIT;
      flag_o <= '0;
    end else if (soft_rst_o) begin
      ext_o  <= EXT_INIT;
      ctrl_o <= CTRL_INIT;
      flag_o <= flag_o & FLAG_SURVIVE;
    end else begin
      if (wr_ext)  ext_o  <= data_i;
      if (wr_flag) flag_o <= (data_i & ~FLAG_CLR_ONLY) |
                             (data_i & flag_o & FLAG_CLR_ONLY);
      if (wr_ctrl) ctrl_o <= ((data_i & ~CTRL_NO_SET) |
                              (data_i & ctrl_o & CTRL_NO_SET)) & ~CTRL_SRST;
    end
  end

endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_start_i,
  input  logic       rd_start_i,
  input  logic       stop_i,
  input  logic       wdata_valid_i,
  input  logic [7:0] wdata_i,
  input  logic       rdata_req_i,
  output logic [7:0] rdata_o,
  output logic       rdata_valid_o,
  input  logic [5:0] live_sec_i,
  input  logic [5:0] live_min_i,
  input  logic [4:0] live_hour_i,
  input  logic [2:0] live_wday_i,
  input  logic [4:0] live_mday_i,
  input  logic [3:0] live_mon_i,
  input  logic [6:0] live_year_i,
  output logic       load_o,
  output logic [2:0] load_sel_o,
  output logic [7:0] load_val_o
);

  localparam int AW = ADDR_W;
  localparam int DW = BYTE_W;

  logic [AW-1:0] ptr;
  logic          addr_phase;
  logic          data_wr;
  logic          wrap;
  logic          soft_rst;
  logic [DW-1:0] ctl_ext, ctl_flag, ctl_ctrl;
  logic [DW-1:0] snap [8];
  logic [DW-1:0] store_rd;
  logic [AW-1:0] store_addr;
  logic          is_time, is_ctl, is_plain;
  logic [DW-1:0] other_d, other_q;
  logic          from_store_q;
  logic          wday_pend_q;
  logic [3:0]    wday_idx_q;

  rtc_ptr_ctrl #(.AW(AW)) u_ptr (
    .clk         (clk),
    .rst         (rst),
    .wr_start_i  (wr_start_i),
    .rd_start_i  (rd_start_i),
    .byte_in_i   (wdata_valid_i),
    .byte_addr_i (wdata_i[AW-1:0]),
    .rd_req_i    (rdata_req_i),
    .soft_rst_i  (soft_rst),
    .ptr_o       (ptr),
    .addr_phase_o(addr_phase),
    .data_wr_o   (data_wr),
    .wrap_o      (wrap)
  );

  rtc_time_snap u_snap (
    .clk        (clk),
    .rst        (rst),
    .capture_i  (rd_start_i || wrap),
    .live_sec_i (live_sec_i),
    .live_min_i (live_min_i),
    .live_hour_i(live_hour_i),
    .live_wday_i(live_wday_i),
    .live_mday_i(live_mday_i),
    .live_mon_i (live_mon_i),
    .live_year_i(live_year_i),
    .snap_o     (snap)
  );

  rtc_ctl_regs #(.DW(DW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (data_wr && is_ctl),
    .addr_i    (ptr[3:0]),
    .data_i    (wdata_i),
    .ext_o     (ctl_ext),
    .flag_o    (ctl_flag),
    .ctrl_o    (ctl_ctrl),
    .soft_rst_o(soft_rst)
  );

  // Address classes: the low nibble decides, bit 4 selects the alias bank.
  assign is_time  = (ptr[3:0] < 4'd7);
  assign is_ctl   = (ptr[3:0] >= 4'hD);
  assign is_plain = !is_time && !is_ctl;
  // Counter bytes in the upper bank fold onto their lower-bank copy.
  assign store_addr = (ptr[4] && (ptr[3:0] == 4'hB || ptr[3:0] == 4'hC)) ?
                      {1'b0, ptr[3:0]} : ptr;

  rtc_byte_store #(.AW(AW), .DW(DW)) u_store (
    .clk    (clk),
    .we_i   (data_wr && is_plain),
    .waddr_i(store_addr),
    .wdata_i(wdata_i),
    .re_i   (rdata_req_i && is_plain),
    .raddr_i(store_addr),
    .rdata_o(store_rd)
  );

  always_comb begin
    case (ptr[3:0])
      4'hD:    other_d = ctl_ext;
      4'hE:    other_d = ctl_flag;
      4'hF:    other_d = ctl_ctrl;
      default: other_d = snap[ptr[2:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      other_q       <= '0;
      from_store_q  <= 1'b0;
      rdata_valid_o <= 1'b0;
    end else begin
      rdata_valid_o <= rdata_req_i;
      if (rdata_req_i) begin
        other_q      <= other_d;
        from_store_q <= is_plain;
      end
    end
  end

  assign rdata_o = from_store_q ? store_rd : other_q;

  // Time presets: immediate for most fields, weekday waits for stop.
  always_ff @(posedge clk) begin
    if (rst) begin
      load_o      <= 1'b0;
      load_sel_o  <= '0;
      load_val_o  <= '0;
      wday_pend_q <= 1'b0;
      wday_idx_q  <= '0;
    end else begin
      load_o <= 1'b0;
      if (data_wr && is_time) begin
        if (ptr[2:0] == FLD_WDAY) begin
          wday_pend_q <= 1'b1;
          wday_idx_q  <= low_index(wdata_i);
        end else begin
          load_o     <= 1'b1;
          load_sel_o <= ptr[2:0];
          load_val_o <= from_bcd(wdata_i & field_mask(ptr[2:0]));
        end
      end else if (stop_i && wday_pend_q) begin
        wday_pend_q <= 1'b0;
        if (wday_idx_q < 4'd7) begin
          load_o     <= 1'b1;
          load_sel_o <= FLD_WDAY;
          load_val_o <= {4'd0, wday_idx_q};
        end
      end
    end
  end

endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
  input logic       clk,
  input logic       rst,
  input logic       wdata_valid_i,
  input logic [7:0] wdata_i,
  input logic       rdata_req_i,
  input logic       stop_i,
  input logic       rdata_valid_o,
  input logic       load_o,
  input logic [2:0] load_sel_o,
  input logic [4:0] ptr,
  input logic       addr_phase,
  input logic [7:0] ctl_ext,
  input logic [7:0] ctl_flag,
  input logic [7:0] ctl_ctrl
);

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wdata_valid_i && !addr_phase && ptr == 5'h1F) |=> (ptr == 5'h00)); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rdata_req_i && !wdata_valid_i && ptr != 5'h1F) |=> (ptr == $past(ptr) + 5'd1)); // R2

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rdata_req_i |=> rdata_valid_o); // R11

  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !rdata_req_i |=> !rdata_valid_o); // R11

  AST_FLAG_CLEAR_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((ctl_flag & ~$past(ctl_flag) & 8'hC7) == 8'h00)); // R6

  AST_CTRL_NO_SET: assert property (@(posedge clk) disable iff (rst)
    ((ctl_ctrl & ~$past(ctl_ctrl) & 8'h06) == 8'h00)); // R7

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
    (wdata_valid_i && !addr_phase && ptr[3:0] == 4'hF && wdata_i[0])
      |=> (ctl_ctrl == 8'h40 && ctl_ext == 8'h02 && ptr == 5'h00)); // R7

  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    load_o |-> $past(wdata_valid_i || stop_i)); // R9

  AST_LOAD_FIELD: assert property (@(posedge clk) disable iff (rst)
    load_o |-> (load_sel_o != 3'd7)); // R9

endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .wdata_valid_i(wdata_valid_i),
  .wdata_i      (wdata_i),
  .rdata_req_i  (rdata_req_i),
  .stop_i       (stop_i),
  .rdata_valid_o(rdata_valid_o),
  .load_o       (load_o),
  .load_sel_o   (load_sel_o),
  .ptr          (ptr),
  .addr_phase   (addr_phase),
  .ctl_ext      (ctl_ext),
  .ctl_flag     (ctl_flag),
  .ctl_ctrl     (ctl_ctrl)
);

// File: tb/rtc_regfile_bench.sv
module rtc_regfile_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_start_i = 0, rd_start_i = 0, stop_i = 0;
  logic       wdata_valid_i = 0, rdata_req_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rdata_o;
  logic       rdata_valid_o;
  logic [5:0] live_sec_i = 0, live_min_i = 0;
  logic [4:0] live_hour_i = 0, live_mday_i = 1;
  logic [2:0] live_wday_i = 0;
  logic [3:0] live_mon_i = 1;
  logic [6:0] live_year_i = 0;
  logic       load_o;
  logic [2:0] load_sel_o;
  logic [7:0] load_val_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [32];

  always #10 clk = ~clk;

  rtc_regfile u_rtc_regfile (
    .clk(clk), .rst(rst),
    .wr_start_i(wr_start_i), .rd_start_i(rd_start_i), .stop_i(stop_i),
    .wdata_valid_i(wdata_valid_i), .wdata_i(wdata_i),
    .rdata_req_i(rdata_req_i), .rdata_o(rdata_o), .rdata_valid_o(rdata_valid_o),
    .live_sec_i(live_sec_i), .live_min_i(live_min_i), .live_hour_i(live_hour_i),
    .live_wday_i(live_wday_i), .live_mday_i(live_mday_i), .live_mon_i(live_mon_i),
    .live_year_i(live_year_i),
    .load_o(load_o), .load_sel_o(load_sel_o), .load_val_o(load_val_o)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] exp_time(input int idx);
    case (idx)
      0: return bcd(int'(live_sec_i));
      1: return bcd(int'(live_min_i));
      2: return bcd(int'(live_hour_i));
      3: return 8'd1 << live_wday_i;
      4: return bcd(int'(live_mday_i));
      5: return bcd(int'(live_mon_i));
      default: return bcd(int'(live_year_i));
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_wr_start();
    @(negedge clk); wr_start_i = 1; @(negedge clk); wr_start_i = 0;
  endtask
  task automatic pulse_rd_start();
    @(negedge clk); rd_start_i = 1; @(negedge clk); rd_start_i = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
  endtask
  task automatic send(input logic [7:0] b);
    @(negedge clk); wdata_valid_i = 1; wdata_i = b;
    @(negedge clk); wdata_valid_i = 0;
  endtask
  task automatic recv(output logic [7:0] b);
    @(negedge clk); rdata_req_i = 1;
    @(negedge clk); rdata_req_i = 0;
    b = rdata_o;
    chk("R11 valid", 32'(rdata_valid_o), 1);
  endtask
  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    pulse_wr_start(); send(a); send(d); pulse_stop();
  endtask
  task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
    pulse_wr_start(); send(a); pulse_rd_start(); recv(d); pulse_stop();
  endtask

  function automatic logic [7:0] plain_addr(input int k);
    if (k < 6) return 8'(7 + k);
    if (k < 10) return 8'(8'h17 + k - 6);
    return 8'(8'h1B + k - 10);
  endfunction

  task automatic set_live(input int s, input int m, input int h, input int w,
                          input int d, input int mo, input int y);
    live_sec_i = 6'(s); live_min_i = 6'(m); live_hour_i = 5'(h);
    live_wday_i = 3'(w); live_mday_i = 5'(d); live_mon_i = 4'(mo); live_year_i = 7'(y);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 rdata_valid", 32'(rdata_valid_o), 0);
    chk("R8 load", 32'(load_o), 0);

    // Full read sweep from pointer 0: capture, aliases, reset values, wrap.
    set_live(37, 5, 23, 6, 29, 12, 99);
    pulse_rd_start();
    for (int i = 0; i < 32; i++) begin
      if (i == 31) set_live(8, 41, 7, 2, 3, 4, 9);
      recv(b);
      if (i < 7)                 chk("R3 capture", 32'(b), 32'(bcd(0) | exp_time(-1) & 8'h0) | 32'(i == 0 ? 8'h37 : i == 1 ? 8'h05 : i == 2 ? 8'h23 : i == 3 ? 8'h40 : i == 4 ? 8'h29 : i == 5 ? 8'h12 : 8'h99));
      if (i >= 16 && i < 23)     chk("R3 alias bank", 32'(b), 32'(i == 16 ? 8'h37 : i == 17 ? 8'h05 : i == 18 ? 8'h23 : i == 19 ? 8'h40 : i == 20 ? 8'h29 : i == 21 ? 8'h12 : 8'h99));
      if (i == 13 || i == 29)    chk("R8 ext reset", 32'(b), 32'h02);
      if (i == 14 || i == 30)    chk("R8 flag reset", 32'(b), 32'h00);
      if (i == 15 || i == 31)    chk("R8 ctrl reset", 32'(b), 32'h40);
    end
    for (int i = 0; i < 7; i++) begin
      recv(b);
      chk("R4 R2 wrap capture", 32'(b), 32'(exp_time(i)));
    end
    pulse_stop();

    // R12 / R1: plain storage and address byte not stored
    write_reg(8'h08, 8'h33);
    pulse_wr_start(); send(8'hE8); pulse_stop();
    read_reg(8'h08, b);
    chk("R1 addr byte not stored", 32'(b), 32'h33);
    pulse_wr_start(); send(8'hE9); send(8'h5A); send(8'hA5); pulse_stop();
    read_reg(8'h09, b); chk("R1 low bits address", 32'(b), 32'h5A);
    read_reg(8'h0A, b); chk("R2 write increment", 32'(b), 32'hA5);

    // R5 aliases
    write_reg(8'h1B, 8'h77);
    read_reg(8'h0B, b); chk("R5 counter alias", 32'(b), 32'h77);
    write_reg(8'h0D, 8'h4C);
    read_reg(8'h1D, b); chk("R5 ext alias", 32'(b), 32'h4C);
    write_reg(8'h1E, 8'h38);
    read_reg(8'h0E, b); chk("R5 flag alias", 32'(b), 32'h38);

    // R6 flag clear-only bits
    write_reg(8'h0E, 8'hFF);
    read_reg(8'h1E, b); chk("R6 protected bits stay 0", 32'(b), 32'h38);
    write_reg(8'h0E, 8'h10);
    read_reg(8'h0E, b); chk("R6 free bits cleared", 32'(b), 32'h10);

    // R7 control set mask and soft reset
    write_reg(8'h0F, 8'h3E);
    read_reg(8'h1F, b); chk("R7 bits 1,2 masked", 32'(b), 32'h38);
    write_reg(8'h0E, 8'h38);
    pulse_wr_start(); send(8'h1F); send(8'h01); pulse_stop();
    set_live(12, 34, 5, 1, 15, 6, 24);
    pulse_rd_start();
    for (int i = 0; i < 16; i++) begin
      recv(b);
      if (i == 0)  chk("R7 pointer to 0", 32'(b), 32'h12);
      if (i == 13) chk("R7 ext to 02", 32'(b), 32'h02);
      if (i == 14) chk("R7 flag keeps 0,1", 32'(b), 32'h00);
      if (i == 15) chk("R7 ctrl to 40", 32'(b), 32'h40);
    end
    pulse_stop();

    // R9 / R10 time writes
    pulse_wr_start(); send(8'h00);
    send(8'hD9); chk("R9 sec strobe", 32'({load_o, load_sel_o, load_val_o}), 32'({1'b1, 3'd0, 8'd59}));
    send(8'h45); chk("R9 min", 32'({load_o, load_sel_o, load_val_o}), 32'({1'b1, 3'd1, 8'd45}));
    send(8'hE3); chk("R9 hour mask", 32'({load_o, load_sel_o, load_val_o}), 32'({1'b1, 3'd2, 8'd23}));
    send(8'h28); chk("R10 weekday deferred", 32'(load_o), 0);
    send(8'hF1); chk("R9 day mask", 32'({load_o, load_sel_o, load_val_o}), 32'({1'b1, 3'd4, 8'd31}));
    @(negedge clk); chk("R9 one cycle", 32'(load_o), 0);
    send(8'hF2); chk("R9 month mask", 32'({load_o, load_sel_o, load_val_o}), 32'({1'b1, 3'd5, 8'd12}));
    send(8'h99); chk("R9 year", 32'({load_o, load_sel_o, load_val_o}), 32'({1'b1, 3'd6, 8'd99}));
    pulse_stop(); chk("R10 weekday on stop", 32'({load_o, load_sel_o, load_val_o}), 32'({1'b1, 3'd3, 8'd3}));
    write_reg(8'h13, 8'h80);
    chk("R10 invalid weekday ignored", 32'(load_o), 0);
    write_reg(8'h13, 8'h00);
    chk("R10 empty weekday ignored", 32'(load_o), 0);

    // R12 random plain storage, R3 random captures
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    for (int k = 0; k < 12; k++) begin
      logic [7:0] a = plain_addr(k);
      write_reg(a, 8'h00);
    end
    for (int n = 0; n < 40; n++) begin
      logic [7:0] a = plain_addr(int'($urandom % 12));
      logic [7:0] d = 8'($urandom);
      write_reg(a, d);
      model[(a == 8'h1B || a == 8'h1C) ? a - 8'h10 : a] = d;
    end
    for (int k = 0; k < 12; k++) begin
      logic [7:0] a = plain_addr(k);
      read_reg(a, b);
      chk("R12 plain storage", 32'(b), 32'(model[(a == 8'h1B || a == 8'h1C) ? a - 8'h10 : a]));
    end
    for (int n = 0; n < 8; n++) begin
      set_live(int'($urandom % 60), int'($urandom % 60), int'($urandom % 24), int'($urandom % 7),
               1 + int'($urandom % 31), 1 + int'($urandom % 12), int'($urandom % 100));
      pulse_wr_start(); send(8'h10); pulse_rd_start();
      for (int i = 0; i < 7; i++) begin
        recv(b);
        chk("R3 random capture", 32'(b), 32'(exp_time(i)));
      end
      pulse_stop();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule